// File: doc/BRIEF.md
# Microcoded Accumulator Processor

This block is a small accumulator machine whose control is a stored microprogram rather than a hardwired state machine. A 128-word by 20-bit control store holds the fetch routine, an indirect-address subroutine and the routines for four memory-reference instructions: add, branch-if-negative, store and exchange. A 7-bit micro-address register walks through the store. Each cycle, one control word is executed. Three independent 3-bit operation fields in that word drive transfers among the accumulator, the data register, the address register and the program counter. The other fields of the word choose the next micro-address.

An instruction word carries an indirect flag in bit 15, a 4-bit opcode in bits 14..11 and an 11-bit address in bits 10..0. Opcodes 0 to 3 are add, branch, store and exchange. The other twelve opcodes map to one-word routines that go straight back to fetch. Main memory sits outside the block behind a plain single-cycle port with a combinational read and a write that is taken on the clock edge. The port has no valid/ready handshake and no back-pressure: memory must answer within the cycle that presents the address. The accumulator, program counter and micro-address are brought out so that the surrounding logic can observe progress.

Top module: `ucode_cpu`

## Requirements
- R1: While reset is low and on the first cycle after it is released, the micro-address is 64 and the accumulator and program counter are 0.
- R2: Fetch takes micro-addresses 64, 65 and 66 in that order. It reads the word at the program counter and advances the program counter by one. It then jumps to micro-address 4 times the opcode held in bits 14..11 of that word.
- R3: Opcode 0 adds the memory word at the effective address to the accumulator, modulo 2^16.
- R4: Opcode 1 loads the program counter with the effective address when accumulator bit 15 is 1, and leaves the program counter unchanged otherwise.
- R5: Opcode 2 writes the accumulator to the effective address and leaves the accumulator unchanged.
- R6: Opcode 3 swaps the accumulator with the memory word at the effective address.
- R7: When bit 15 of the instruction is 1, the effective address is bits 10..0 of the memory word at the instruction's address field. When bit 15 is 0, the effective address is the address field itself. A branch that is not taken never resolves the address.
- R8: Opcodes 4 to 15 leave the accumulator and memory unchanged and only advance the program counter.
- R9: The memory write enable is asserted for exactly one cycle per store and per exchange, never in two consecutive cycles, and never for any other instruction.
- R10: Including fetch, an instruction takes 6 cycles for add and store, 7 for exchange, 5 for a branch that is not taken, 6 for a taken branch and 4 for opcodes 4 to 15. Indirect addressing adds 2 cycles to each case that resolves an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 11 | Memory address, driven from the address register |
| mem_wdata | output | 16 | Write data, driven from the data register |
| mem_we | output | 1 | Write enable; memory stores on the rising edge |
| mem_rdata | input | 16 | Read data for mem_addr, valid in the same cycle |
| acc | output | 16 | Accumulator |
| pc | output | 11 | Program counter |
| upc | output | 7 | Current micro-address |

## Verification
An instruction's results appear when the micro-address next reads 64. That happens 4 to 9 cycles after the previous return to 64, depending on the opcode, the indirect flag and the branch outcome (R10). The bench samples on the falling edge and counts cycles until upc returns to 64. At that point it compares the accumulator, the program counter, the memory word at the effective address and the number of write cycles against an instruction-level model stepped once per instruction. The cycle count itself is checked against the expected length, so any early or late return is caught. The properties cover the fixed three-cycle fetch sequence and the single-cycle write pulse cycle by cycle.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int CAW = 7;
  localparam int OPW = 4;

  typedef struct packed {
    logic [2:0]     f1;
    logic [2:0]     f2;
    logic [2:0]     f3;
    logic [1:0]     cd;
    logic [1:0]     br;
    logic [CAW-1:0] ad;
  } uword_t;

  localparam logic [CAW-1:0] FETCH_ORG = 7'd64;
  localparam logic [CAW-1:0] INDIR_ORG = 7'd67;

  // condition select
  localparam logic [1:0] CD_ONE = 2'd0, CD_IND = 2'd1, CD_NEG = 2'd2, CD_ZERO = 2'd3;
  // next-address kind
  localparam logic [1:0] BR_JMP = 2'd0, BR_CALL = 2'd1, BR_RET = 2'd2, BR_MAP = 2'd3;

  localparam logic [2:0] OP_NONE   = 3'd0;
  // first field
  localparam logic [2:0] F1_ADDM   = 3'd1, F1_CLRA  = 3'd2, F1_INCA = 3'd3, F1_DR2A = 3'd4,
                         F1_DR2AR  = 3'd5, F1_PC2AR = 3'd6, F1_WR   = 3'd7;
  // second field
  localparam logic [2:0] F2_SUBM   = 3'd1, F2_ORM   = 3'd2, F2_ANDM = 3'd3, F2_RD   = 3'd4,
                         F2_A2DR   = 3'd5, F2_INCDR = 3'd6, F2_PC2DR = 3'd7;
  // third field
  localparam logic [2:0] F3_XORM   = 3'd1, F3_CPL   = 3'd2, F3_SHL  = 3'd3, F3_SHR  = 3'd4,
                         F3_INCPC  = 3'd5, F3_AR2PC = 3'd6;

  function automatic uword_t mk(logic [2:0] a, logic [2:0] b, logic [2:0] c,
                                logic [1:0] cond, logic [1:0] kind, logic [CAW-1:0] tgt);
    uword_t w;
    w.f1 = a; w.f2 = b; w.f3 = c; w.cd = cond; w.br = kind; w.ad = tgt;
    return w;
  endfunction
endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
  import ucode_pkg::*;
(
  input  logic [CAW-1:0] addr,
  output uword_t         word
);
  always_comb begin
    case (addr)
      // opcode 0: add
      7'd0:  word = mk(OP_NONE,  OP_NONE, OP_NONE,  CD_IND, BR_CALL, INDIR_ORG);
      7'd1:  word = mk(OP_NONE,  F2_RD,   OP_NONE,  CD_ONE, BR_JMP,  7'd2);
      7'd2:  word = mk(F1_ADDM,  OP_NONE, OP_NONE,  CD_ONE, BR_JMP,  FETCH_ORG);
      // opcode 1: branch if negative
      7'd4:  word = mk(OP_NONE,  OP_NONE, OP_NONE,  CD_NEG, BR_JMP,  7'd6);
      7'd6:  word = mk(OP_NONE,  OP_NONE, OP_NONE,  CD_IND, BR_CALL, INDIR_ORG);
      7'd7:  word = mk(OP_NONE,  OP_NONE, F3_AR2PC, CD_ONE, BR_JMP,  FETCH_ORG);
      // opcode 2: store
      7'd8:  word = mk(OP_NONE,  OP_NONE, OP_NONE,  CD_IND, BR_CALL, INDIR_ORG);
      7'd9:  word = mk(OP_NONE,  F2_A2DR, OP_NONE,  CD_ONE, BR_JMP,  7'd10);
      7'd10: word = mk(F1_WR,    OP_NONE, OP_NONE,  CD_ONE, BR_JMP,  FETCH_ORG);
      // opcode 3: exchange
      7'd12: word = mk(OP_NONE,  OP_NONE, OP_NONE,  CD_IND, BR_CALL, INDIR_ORG);
      7'd13: word = mk(OP_NONE,  F2_RD,   OP_NONE,  CD_ONE, BR_JMP,  7'd14);
      7'd14: word = mk(F1_DR2A,  F2_A2DR, OP_NONE,  CD_ONE, BR_JMP,  7'd15);
      7'd15: word = mk(F1_WR,    OP_NONE, OP_NONE,  CD_ONE, BR_JMP,  FETCH_ORG);
      // fetch
      7'd64: word = mk(F1_PC2AR, OP_NONE, OP_NONE,  CD_ONE, BR_JMP,  7'd65);
      7'd65: word = mk(OP_NONE,  F2_RD,   F3_INCPC, CD_ONE, BR_JMP,  7'd66);
      7'd66: word = mk(F1_DR2AR, OP_NONE, OP_NONE,  CD_ONE, BR_MAP,  7'd0);
      // indirect resolution subroutine
      7'd67: word = mk(OP_NONE,  F2_RD,   OP_NONE,  CD_ONE, BR_JMP,  7'd68);
      7'd68: word = mk(F1_DR2AR, OP_NONE, OP_NONE,  CD_ONE, BR_RET,  7'd0);
      // every other word returns to fetch
      default: word = mk(OP_NONE, OP_NONE, OP_NONE, CD_ONE, BR_JMP, FETCH_ORG);
    endcase
  end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     cd,
  input  logic [1:0]     br,
  input  logic [CAW-1:0] ad,
  input  logic           dr_ind,
  input  logic           ac_neg,
  input  logic           ac_zero,
  input  logic [OPW-1:0] map_op,
  output logic [CAW-1:0] car
);
  localparam int PADW = CAW - OPW - 3;

  logic [CAW-1:0] sbr, car_inc, car_nxt, map_addr;
  logic           test;

  assign car_inc  = car + 1'b1;
  assign map_addr = {{(PADW+1){1'b0}}, map_op, 2'b00};

  always_comb begin
    case (cd)
      CD_IND:  test = dr_ind;
      CD_NEG:  test = ac_neg;
      CD_ZERO: test = ac_zero;
      default: test = 1'b1;
    endcase
    case (br)
      BR_RET:  car_nxt = sbr;
      BR_MAP:  car_nxt = map_addr;
      default: car_nxt = test ? ad : car_inc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car <= FETCH_ORG;
      sbr <= '0;
    end else begin
      car <= car_nxt;
      if (br == BR_CALL && test) sbr <= car_inc;
    end
  end
endmodule

// File: rtl/ucode_dp.sv
module ucode_dp
  import ucode_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    f1,
  input  logic [2:0]    f2,
  input  logic [2:0]    f3,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] ac,
  output logic [DW-1:0] dr,
  output logic [AW-1:0] ar,
  output logic [AW-1:0] pc
);
  logic [DW-1:0] ac_n, dr_n;
  logic [AW-1:0] ar_n, pc_n;

  // later fields are applied first so that F1 wins over F2 over F3
  always_comb begin
    ac_n = ac; dr_n = dr; ar_n = ar; pc_n = pc;
    case (f3)
      F3_XORM:  ac_n = ac ^ dr;
      F3_CPL:   ac_n = ~ac;
      F3_SHL:   ac_n = ac << 1;
      F3_SHR:   ac_n = ac >> 1;
      F3_INCPC: pc_n = pc + 1'b1;
      F3_AR2PC: pc_n = ar;
      default:  ;
    endcase
    case (f2)
      F2_SUBM:  ac_n = ac - dr;
      F2_ORM:   ac_n = ac | dr;
      F2_ANDM:  ac_n = ac & dr;
      F2_RD:    dr_n = rdata;
      F2_A2DR:  dr_n = ac;
      F2_INCDR: dr_n = dr + 1'b1;
      F2_PC2DR: dr_n = {dr[DW-1:AW], pc};
      default:  ;
    endcase
    case (f1)
      F1_ADDM:  ac_n = ac + dr;
      F1_CLRA:  ac_n = '0;
      F1_INCA:  ac_n = ac + 1'b1;
      F1_DR2A:  ac_n = dr;
      F1_DR2AR: ar_n = dr[AW-1:0];
      F1_PC2AR: ar_n = pc;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac <= '0; dr <= '0; ar <= '0; pc <= '0;
    end else begin
      ac <= ac_n; dr <= dr_n; ar <= ar_n; pc <= pc_n;
    end
  end
endmodule

// File: rtl/ucode_cpu.sv
module ucode_cpu
  import ucode_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] acc,
  output logic [AW-1:0] pc,
  output logic [CAW-1:0] upc
);
  uword_t        uw;
  logic [DW-1:0] dr;
  logic [AW-1:0] ar;

  ucode_rom u_rom (.addr(upc), .word(uw));

  ucode_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cd(uw.cd), .br(uw.br), .ad(uw.ad),
    .dr_ind(dr[DW-1]), .ac_neg(acc[DW-1]), .ac_zero(acc == '0),
    .map_op(dr[DW-2 -: OPW]), .car(upc)
  );

  ucode_dp #(.DW(DW), .AW(AW)) u_dp (
    .clk(clk), .rst_n(rst_n), .f1(uw.f1), .f2(uw.f2), .f3(uw.f3),
    .rdata(mem_rdata), .ac(acc), .dr(dr), .ar(ar), .pc(pc)
  );

  assign mem_addr  = ar;
  assign mem_wdata = dr;
  assign mem_we    = (uw.f1 == F1_WR);
endmodule

// File: rtl/ucode_cpu_chk.sv
module ucode_cpu_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic [6:0]    upc,
  input logic [AW-1:0] pc,
  input logic          mem_we
);
  AST_RESET_ENTRY: assert property (@(posedge clk) !rst_n |=> (upc == 7'd64)); // R1
  AST_FETCH_STEP1: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 7'd64) |=> (upc == 7'd65)); // R2
  AST_FETCH_STEP2: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 7'd65) |=> (upc == 7'd66) && (pc == AW'($past(pc) + 1'b1))); // R2
  AST_MAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 7'd66) |=> (upc[6] == 1'b0) && (upc[1:0] == 2'b00)); // R10
  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R9
endmodule

bind ucode_cpu ucode_cpu_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_ucode_cpu.sv
module test_ucode_cpu;
  localparam int CLK_PERIOD = 10;
  localparam int NINST = 1500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, acc;
  logic        mem_we;
  logic [10:0] pc;
  logic [6:0]  upc;

  logic [15:0] mem [0:2047];
  logic [15:0] rmem [0:2047];
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  ucode_cpu i_ucode_cpu (.*);

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic rnd(output logic [31:0] r);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    r = seed;
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [3:0] op, input logic ind);
    if (ind && op <= 4'd3) return "R7";
    case (op)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      default: return "R8";
    endcase
  endfunction

  initial begin
    logic [31:0] r;
    for (int a = 0; a < 2048; a++) mem[a] = '0;
    // code words
    for (int a = 0; a < 512; a++) begin
      logic [3:0] op;
      logic ind;
      logic [10:0] ad;
      rnd(r);
      case (r[2:0])
        3'd0, 3'd5: op = 4'd0;
        3'd2, 3'd7: op = 4'd1;
        3'd3: op = 4'd2;
        3'd4: op = 4'd3;
        3'd1: op = 4'd0;
        default: op = 4'd4 + 4'(r[6:3] % 12);
      endcase
      ind = (r[10:9] == 2'b00);
      if (op == 4'd1) ad = ind ? 11'(512 + r[14:11]) : 11'(r[20:13]);
      else            ad = ind ? 11'(528 + r[14:11]) : 11'(1024 + r[21:16]);
      mem[a] = {ind, op, ad};
    end
    for (int a = 512; a < 528; a++) begin rnd(r); mem[a] = {8'h00, r[7:0]}; end
    for (int a = 528; a < 544; a++) begin rnd(r); mem[a] = 16'(1024 + r[5:0]); end
    for (int a = 1024; a < 1088; a++) begin rnd(r); mem[a] = r[15:0]; end
    for (int a = 0; a < 2048; a++) rmem[a] = mem[a];
  end

  initial begin
    logic [15:0] rac, w;
    logic [10:0] rpc, ea;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "upc in reset", int'(upc), 64);
    chk("R1", "acc in reset", int'(acc), 0);
    chk("R1", "pc in reset", int'(pc), 0);
    rst_n = 1'b1;
    chk("R1", "upc after release", int'(upc), 64);
    rac = '0; rpc = '0;
    for (int n = 0; n < NINST; n++) begin
      int cyc, wr, exp_cyc, exp_wr;
      logic [3:0] op;
      logic ind, neg, resolve;
      string tag;
      cyc = 0; wr = 0;
      do begin
        @(negedge clk);
        cyc++;
        if (mem_we) wr++;
      end while (upc != 7'd64);
      // model step
      w = rmem[rpc];
      rpc = rpc + 1'b1;
      op = w[14:11]; ind = w[15]; neg = rac[15];
      resolve = (op <= 4'd3) && !(op == 4'd1 && !neg);
      ea = (ind && resolve) ? rmem[w[10:0]][10:0] : w[10:0];
      exp_wr = 0;
      case (op)
        4'd0: begin rac = rac + rmem[ea]; exp_cyc = 6; end
        4'd1: begin if (neg) rpc = ea; exp_cyc = neg ? 6 : 5; end
        4'd2: begin rmem[ea] = rac; exp_cyc = 6; exp_wr = 1; end
        4'd3: begin w = rmem[ea]; rmem[ea] = rac; rac = w; exp_cyc = 7; exp_wr = 1; end
        default: exp_cyc = 4;
      endcase
      if (ind && resolve) exp_cyc += 2;
      tag = op_tag(op, ind);
      chk(tag, "acc", int'(acc), int'(rac));
      chk(tag, "pc (R2 fetch/branch)", int'(pc), int'(rpc));
      chk("R10", "cycles", cyc, exp_cyc);
      chk("R9", "write cycles", wr, exp_wr);
      if (op == 4'd2 || op == 4'd3)
        chk(tag, "memory at ea", int'(mem[ea]), int'(rmem[ea]));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule